// File: doc/BRIEF.md
# Processor Status Register

This block holds the eight-bit status word of a small accumulator-style microcontroller core. The word has three parts. Three arithmetic flags (zero, digit carry, carry) come from the ALU. Two reset-cause flags record whether the core timed out or went to sleep. Three bank-select bits steer direct and indirect data addressing. The register sits on the core's internal data bus, so any instruction can read it or write it. It also takes flag results from the ALU, with a separate enable for each flag, and single-cycle strobes from the power-on logic, the watchdog and the sleep decoder.

A bus write does not always reach every bit. The two reset-cause bits never take bus data. When the instruction that writes the register also produces arithmetic flags, the bus value does not reach the three flag bits. Each flag the ALU enables takes the ALU result, and each flag it does not enable keeps its old value. Clearing the register with an instruction that sets the zero flag therefore leaves the pattern `000u u1uu`, where `u` means unchanged. The bank-select output feeds the data-memory address decoder.

Top module: `cpu_status_reg`

## Requirements
- R1: When `por_i` is high at a clock edge, TO (bit 4) and PD (bit 3) become 1 and IRP, RP1 and RP0 (bits 7:5) become 0. This happens whether or not `rst_n` is low, and it overrides a bus write to bits 7:5 in the same cycle.
- R2: While `rst_n` is low, bits 7:5 and the arithmetic flags Z, DC and C (bits 2:0) are held at 0, without waiting for a clock edge. TO and PD keep their values.
- R3: `rd_data_o` always shows the current register, from MSB to LSB: IRP, RP1, RP0, TO, PD, Z, DC, C.
- R4: A bus write (`wr_en_i` high) with `flag_we_i` equal to 0 loads `wr_data_i` bits 7:5 and 2:0 at the next clock edge.
- R5: TO and PD never take bus data. With no event strobe high, they keep their values.
- R6: When any bit of `flag_we_i` is high, a bus write does not change bits 2:0. Each flag whose enable is low keeps its value. The bit mapping for `flag_we_i` and `flag_val_i` is: bit 2 = Z, bit 1 = DC, bit 0 = C.
- R7: At a clock edge, each flag whose enable bit is high takes its `flag_val_i` bit. This holds with or without a bus write.
- R8: A `wdt_clr_i` strobe sets both TO and PD to 1.
- R9: A `sleep_i` strobe sets TO to 1 and clears PD to 0.
- R10: A `wdt_to_i` strobe clears TO to 0 and leaves PD unchanged.
- R11: When several event strobes are high in the same cycle, only the highest-priority one acts. The order is `por_i`, then `wdt_to_i`, then `sleep_i`, then `wdt_clr_i`.
- R12: `bank_sel_o` equals RP0 (bit 5). A value of 0 selects the lower 128-byte bank and 1 selects the upper bank.
- R13: A bus write of 0x00 together with a Z update to 1 (and DC and C not enabled) leaves the register as `000u u1uu`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low core reset; does not touch the reset-cause bits |
| por_i | input | 1 | Power-on event strobe |
| wdt_clr_i | input | 1 | Watchdog-clear event strobe |
| sleep_i | input | 1 | Sleep event strobe |
| wdt_to_i | input | 1 | Watchdog time-out event strobe |
| wr_en_i | input | 1 | Bus write strobe |
| wr_data_i | input | 8 | Bus write data |
| flag_we_i | input | 3 | Per-flag update enables {Z, DC, C} |
| flag_val_i | input | 3 | ALU flag results {Z, DC, C} |
| rd_data_o | output | 8 | Register read value |
| bank_sel_o | output | 1 | Data-memory bank select (RP0) |

## Verification
Bus writes are tried with all-ones and all-zeros data while TO is 0 and while PD is 0. This shows whether the reset-cause bits take bus data, and it separates writable bits from read-only bits. Flag updates are tried with enables that select only Z, with mixed enables together with a write, and with no write at all. These three patterns tell apart the three possible rules for arithmetic bits: masked, suppressed, or loaded from the bus. The event strobes are applied one at a time and then in overlapping groups, which shows that the priority order is correct. An asynchronous core reset is applied with TO at 0, which separates the core reset from the power-on event.

// File: rtl/psr_pkg.sv
package psr_pkg;
   localparam int PSR_W     = 8;
   localparam int IDX_C     = 0;
   localparam int IDX_DC    = 1;
   localparam int IDX_Z     = 2;
   localparam int IDX_PD    = 3;
   localparam int IDX_TO    = 4;
   localparam int IDX_RP0   = 5;
   localparam int IDX_RP1   = 6;
   localparam int IDX_IRP   = 7;
   localparam int ARITH_N   = 3;
   localparam int ARITH_LSB = IDX_C;
   localparam int BANK_N    = 3;
   localparam int BANK_LSB  = IDX_RP0;

   typedef struct packed {
      logic por;
      logic wdt_to;
      logic sleep;
      logic wdt_clr;
   } psr_evt_t;

   typedef enum logic [2:0] {
      EV_NONE    = 3'd0,
      EV_POWERON = 3'd1,
      EV_TIMEOUT = 3'd2,
      EV_SLEEP   = 3'd3,
      EV_WAKE    = 3'd4
   } psr_ev_e;

   function automatic psr_ev_e pick_event(input psr_evt_t e);
      if (e.por)          return EV_POWERON;
      else if (e.wdt_to)  return EV_TIMEOUT;
      else if (e.sleep)   return EV_SLEEP;
      else if (e.wdt_clr) return EV_WAKE;
      else                return EV_NONE;
   endfunction
endpackage

// File: rtl/psr_cause_flags.sv
module psr_cause_flags
   import psr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  psr_evt_t evt_i,
   output logic     to_o,
   output logic     pd_o
);
   psr_ev_e ev;
   logic    to_q, pd_q;

   always_comb ev = pick_event(evt_i);

   // No rst_n here: only the power-on event touches the cause bits.
   always_ff @(posedge clk) begin
      unique case (ev)
         EV_POWERON: begin to_q <= 1'b1; pd_q <= 1'b1; end
         EV_TIMEOUT: begin to_q <= 1'b0;               end
         EV_SLEEP:   begin to_q <= 1'b1; pd_q <= 1'b0; end
         EV_WAKE:    begin to_q <= 1'b1; pd_q <= 1'b1; end
         default:    ;
      endcase
   end

   assign to_o = to_q;
   assign pd_o = pd_q;

   assert_poweron_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i.por |=> (to_o && pd_o));
   assert_cause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == '0) |=> ($stable(to_o) && $stable(pd_o)));
   assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.wdt_clr && !evt_i.por && !evt_i.wdt_to && !evt_i.sleep) |=> (to_o && pd_o));
   assert_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.sleep && !evt_i.por && !evt_i.wdt_to) |=> (to_o && !pd_o));
   assert_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i.wdt_to && !evt_i.por) |=> (!to_o && $stable(pd_o)));
endmodule

// File: rtl/psr_arith_flags.sv
module psr_arith_flags
   import psr_pkg::*;
#(
   parameter bit                 RST_EN  = 1'b1,
   parameter logic [ARITH_N-1:0] RST_VAL = '0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [ARITH_N-1:0] wr_bits_i,
   input  logic [ARITH_N-1:0] upd_we_i,
   input  logic [ARITH_N-1:0] upd_val_i,
   output logic [ARITH_N-1:0] flags_o
);
   logic               alu_owns;
   logic [ARITH_N-1:0] nxt;

   assign alu_owns = |upd_we_i;

   for (genvar i = 0; i < ARITH_N; i++) begin : g_flag
      always_comb begin
         if (alu_owns)     nxt[i] = upd_we_i[i] ? upd_val_i[i] : flags_o[i];
         else if (wr_en_i) nxt[i] = wr_bits_i[i];
         else              nxt[i] = flags_o[i];
      end

      if (RST_EN) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_o[i] <= RST_VAL[i];
            else        flags_o[i] <= nxt[i];
         end
      end else begin : g_norst
         always_ff @(posedge clk) flags_o[i] <= nxt[i];
      end
   end

   assert_bus_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && upd_we_i == '0) |=> (flags_o == $past(wr_bits_i)));
   assert_masked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_we_i != '0) |=> (((flags_o ^ $past(flags_o)) & ~$past(upd_we_i)) == '0));
   assert_alu_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_we_i != '0) |=> (((flags_o ^ $past(upd_val_i)) & $past(upd_we_i)) == '0));
endmodule

// File: rtl/psr_bank_bits.sv
module psr_bank_bits
   import psr_pkg::*;
#(
   parameter logic [BANK_N-1:0] RST_VAL = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_i,
   input  logic              wr_en_i,
   input  logic [BANK_N-1:0] wr_bits_i,
   output logic [BANK_N-1:0] bits_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bits_o <= RST_VAL;
      else if (por_i)   bits_o <= RST_VAL;
      else if (wr_en_i) bits_o <= wr_bits_i;
   end

   assert_bank_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !por_i) |=> (bits_o == $past(wr_bits_i)));
   assert_bank_por_R1: assert property (@(posedge clk) disable iff (!rst_n)
      por_i |=> (bits_o == RST_VAL));
   assert_bank_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && !por_i) |=> $stable(bits_o));
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
   import psr_pkg::*;
#(
   parameter int                 DATA_W        = 8,
   parameter bit                 ARITH_RST_EN  = 1'b1,
   parameter logic [ARITH_N-1:0] ARITH_RST_VAL = '0,
   parameter logic [BANK_N-1:0]  BANK_RST_VAL  = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_i,
   input  logic              wdt_clr_i,
   input  logic              sleep_i,
   input  logic              wdt_to_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ARITH_N-1:0] flag_we_i,
   input  logic [ARITH_N-1:0] flag_val_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              bank_sel_o
);
   if (DATA_W != PSR_W) begin : g_bad_width
      $error("cpu_status_reg: DATA_W must equal the status word width");
   end

   psr_evt_t          evt;
   logic [ARITH_N-1:0] arith;
   logic [BANK_N-1:0]  bank;
   logic               to_bit, pd_bit;
   logic               unused_cause_data;

   assign evt = '{por: por_i, wdt_to: wdt_to_i, sleep: sleep_i, wdt_clr: wdt_clr_i};
   assign unused_cause_data = ^wr_data_i[IDX_PD +: 2];

   psr_cause_flags u_cause (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt),
      .to_o  (to_bit),
      .pd_o  (pd_bit)
   );

   psr_arith_flags #(
      .RST_EN  (ARITH_RST_EN),
      .RST_VAL (ARITH_RST_VAL)
   ) u_arith (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_bits_i (wr_data_i[ARITH_LSB +: ARITH_N]),
      .upd_we_i  (flag_we_i),
      .upd_val_i (flag_val_i),
      .flags_o   (arith)
   );

   psr_bank_bits #(
      .RST_VAL (BANK_RST_VAL)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_i     (por_i),
      .wr_en_i   (wr_en_i),
      .wr_bits_i (wr_data_i[BANK_LSB +: BANK_N]),
      .bits_o    (bank)
   );

   always_comb begin
      rd_data_o                        = '0;
      rd_data_o[BANK_LSB +: BANK_N]    = bank;
      rd_data_o[IDX_TO]                = to_bit;
      rd_data_o[IDX_PD]                = pd_bit;
      rd_data_o[ARITH_LSB +: ARITH_N]  = arith;
   end

   assign bank_sel_o = bank[IDX_RP0 - BANK_LSB];

   assert_cause_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !por_i && !wdt_to_i && !sleep_i && !wdt_clr_i)
      |=> ($stable(rd_data_o[IDX_TO]) && $stable(rd_data_o[IDX_PD])));
   assert_clear_pattern_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i == '0 && flag_we_i == 3'b100 && flag_val_i[2] &&
       !por_i && !wdt_to_i && !sleep_i && !wdt_clr_i)
      |=> (rd_data_o[7:5] == 3'b000 && rd_data_o[IDX_Z] &&
           $stable(rd_data_o[IDX_TO]) && $stable(rd_data_o[IDX_PD]) &&
           $stable(rd_data_o[IDX_DC]) && $stable(rd_data_o[IDX_C])));
endmodule

// File: tb/cpu_status_reg_bench.sv
module cpu_status_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n, por, wclr, slp, wto, wr_en;
   logic [7:0] wr_data, rd;
   logic [2:0] fwe, fval;
   logic       bsel;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   cpu_status_reg u_cpu_status_reg (
      .clk(clk), .rst_n(rst_n), .por_i(por), .wdt_clr_i(wclr), .sleep_i(slp),
      .wdt_to_i(wto), .wr_en_i(wr_en), .wr_data_i(wr_data), .flag_we_i(fwe),
      .flag_val_i(fval), .rd_data_o(rd), .bank_sel_o(bsel)
   );

   task automatic idle();
      por = 0; wclr = 0; slp = 0; wto = 0; wr_en = 0; wr_data = '0; fwe = '0; fval = '0;
   endtask

   // drive at negedge, one posedge passes, sample at next negedge
   task automatic step(input logic w, input logic [7:0] d, input logic [2:0] we,
                       input logic [2:0] v, input logic [3:0] ev);
      @(negedge clk);
      wr_en = w; wr_data = d; fwe = we; fval = v;
      {por, wto, slp, wclr} = ev;
      @(negedge clk);
      idle();
   endtask

   task automatic chk(input string req, input logic [7:0] exp);
      total++;
      if (rd !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, rd, exp);
      end
   endtask

   task automatic chk_bit(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic t_poweron();
      idle(); rst_n = 0;
      step(0, 8'h00, 3'b000, 3'b000, 4'b1000);
      @(negedge clk); rst_n = 1;
      chk("R1 R2 R3 poweron value", 8'h18);
      chk_bit("R12 bank after poweron", bsel, 1'b0);
   endtask

   task automatic t_bus_write();
      step(0, 8'h00, 3'b000, 3'b000, 4'b0100);
      chk("R10 timeout clears TO", 8'h08);
      step(1, 8'hFF, 3'b000, 3'b000, 4'b0000);
      chk("R4 R5 write ones, TO stays 0", 8'hEF);
      step(1, 8'h00, 3'b000, 3'b000, 4'b0000);
      chk("R4 R5 write zeros, PD stays 1", 8'h08);
      step(0, 8'h00, 3'b000, 3'b000, 4'b0001);
      chk("R8 watchdog clear", 8'h18);
   endtask

   task automatic t_sleep();
      step(0, 8'h00, 3'b000, 3'b000, 4'b0010);
      chk("R9 sleep", 8'h10);
      step(1, 8'h08, 3'b000, 3'b000, 4'b0000);
      chk("R5 PD ignores bus", 8'h10);
      step(0, 8'h00, 3'b000, 3'b000, 4'b0001);
      chk("R8 wake from sleep", 8'h18);
   endtask

   task automatic t_flags();
      step(1, 8'hE3, 3'b000, 3'b000, 4'b0000);
      chk("R4 load pattern", 8'hFB);
      step(1, 8'h00, 3'b100, 3'b100, 4'b0000);
      chk("R13 clear with Z set", 8'h1F);
      step(1, 8'hFF, 3'b011, 3'b000, 4'b0000);
      chk("R6 suppressed write, mixed enables", 8'hFC);
      step(0, 8'h00, 3'b101, 3'b001, 4'b0000);
      chk("R7 update without write", 8'hF9);
      chk_bit("R12 RP0 high", bsel, 1'b1);
   endtask

   task automatic t_bank();
      step(1, 8'h00, 3'b000, 3'b000, 4'b0000);
      chk_bit("R12 RP0 low", bsel, 1'b0);
      step(1, 8'h20, 3'b000, 3'b000, 4'b0000);
      chk_bit("R12 RP0 only", bsel, 1'b1);
      step(1, 8'h40, 3'b000, 3'b000, 4'b0000);
      chk("R3 R4 RP1 storage", 8'h58);
      chk_bit("R12 RP1 does not select", bsel, 1'b0);
   endtask

   task automatic t_priority();
      step(1, 8'h00, 3'b000, 3'b000, 4'b0000);
      step(0, 8'h00, 3'b000, 3'b000, 4'b0111);
      chk("R11 timeout beats sleep and clear", 8'h08);
      step(0, 8'h00, 3'b000, 3'b000, 4'b0011);
      chk("R11 sleep beats clear", 8'h10);
      step(1, 8'hFF, 3'b000, 3'b000, 4'b1100);
      chk("R1 R11 poweron beats all", 8'h1F);
   endtask

   task automatic t_core_reset();
      step(0, 8'h00, 3'b000, 3'b000, 4'b0100);
      step(1, 8'hE7, 3'b000, 3'b000, 4'b0000);
      chk("R4 setup before reset", 8'hEF);
      #3 rst_n = 0;
      #2 chk("R2 async clear, TO/PD kept", 8'h08);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      chk("R2 after release", 8'h08);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_poweron();
      t_bus_write();
      t_sleep();
      t_flags();
      t_bank();
      t_priority();
      t_core_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule